// File: doc/BRIEF.md
# Saturating predicate-count scalar incrementer

This datapath block counts the active lanes of a predicate mask and adds that count to an unsigned scalar. The mask carries one bit per byte of the vector. A runtime element-size code sets which bit stands for each element: only the lowest bit of each element's byte group is examined. A runtime vector length limits how many elements are examined.

The sum saturates at the largest unsigned value of the selected scalar width, which is 32 or 64 bits. The result is then zero-extended to 64 bits. A guard bit above 64 lets the 64-bit form detect overflow without wrapping. Operands and result are registered once, so every accepted input gives one result one clock later.

Top module: `pred_cnt_incr`

## Requirements
- R1: The element-size code `esz_i` selects the element width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64 bits. Element e is active when predicate bit e*(width/8) is set.
- R2: Only the first `vl_i`/width elements are examined. Predicate bits at index `vl_i`/8 and above have no effect on the result.
- R3: Predicate bits inside an element group other than its lowest bit have no effect on the result.
- R4: With `wide_i`=0 the operand is taken from `opnd_i[31:0]` only. `opnd_i[63:32]` is ignored and `result_o[63:32]` is zero.
- R5: When operand plus count exceeds the unsigned maximum of the selected width, the result is that maximum: 0xFFFFFFFF for 32-bit and all ones for 64-bit.
- R6: When there is no overflow, the result equals operand plus active-element count, and the 64-bit form uses all 64 operand bits.
- R7: An all-zero predicate returns the operand, truncated to the selected width and zero-extended.
- R8: `valid_o` is low after reset and equals `valid_i` one clock later. `result_o` updates one clock after `valid_i` is high and holds its value while `valid_i` is low.
- R9: Every vector length that is a multiple of 128 up to `MAX_VL` is supported. At `vl_i`=`MAX_VL` every predicate position takes part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| vl_i | input | $clog2(MAX_VL+1) | Current vector length in bits |
| esz_i | input | 2 | Element-size code |
| wide_i | input | 1 | 0: 32-bit scalar, 1: 64-bit scalar |
| pred_i | input | MAX_VL/8 | Predicate, one bit per vector byte |
| opnd_i | input | 64 | Scalar operand |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Saturated, zero-extended sum |

## Verification
The result and its valid flag are both due exactly one clock after the input strobe. The bench drives inputs on the falling edge and reads the outputs on the following falling edge, after the single register stage has captured them. On the next cycle the bench holds the strobe low and changes the operand and predicate. It then confirms at the same sampling point that the valid flag has dropped and the result has not moved.

// File: rtl/pred_cnt_pkg.sv
package pred_cnt_pkg;
  localparam int SCALAR_W = 64;
  localparam int HALF_W   = SCALAR_W / 2;
  localparam int SUM_W    = SCALAR_W + 1;  // one guard bit

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  typedef logic [SCALAR_W-1:0] scalar_t;
  typedef logic [SUM_W-1:0]    sum_t;
endpackage

// File: rtl/pred_cnt_lane_mask.sv
module pred_cnt_lane_mask #(
  parameter int PW   = 256,
  parameter int VL_W = 12
) (
  input  logic [VL_W-1:0] vl_i,
  input  logic [1:0]      esz_i,
  input  logic [PW-1:0]   pred_i,
  output logic [PW-1:0]   mask_o
);
  import pred_cnt_pkg::*;

  logic [VL_W-1:0] vl_bytes;
  esz_e            esz;

  assign vl_bytes = vl_i >> 3;
  assign esz      = esz_e'(esz_i);

  for (genvar i = 0; i < PW; i++) begin : g_bit
    localparam logic [VL_W-1:0] IDX = VL_W'(i);
    logic lead;
    always_comb begin
      unique case (esz)
        ESZ_8:   lead = 1'b1;
        ESZ_16:  lead = ((i % 2) == 0);
        ESZ_32:  lead = ((i % 4) == 0);
        default: lead = ((i % 8) == 0);
      endcase
    end
    assign mask_o[i] = pred_i[i] & lead & (IDX < vl_bytes);
  end
endmodule

// File: rtl/pred_cnt_popcount.sv
module pred_cnt_popcount #(
  parameter int W     = 256,
  parameter int CHUNK = 8,
  localparam int CW   = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  localparam int NCH = W / CHUNK;
  localparam int CCW = $clog2(CHUNK + 1);

  logic [CCW-1:0] part [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    always_comb begin
      part[c] = '0;
      for (int j = 0; j < CHUNK; j++) part[c] = part[c] + CCW'(bits_i[c*CHUNK+j]);
    end
  end

  always_comb begin
    count_o = '0;
    for (int c = 0; c < NCH; c++) count_o = count_o + CW'(part[c]);
  end
endmodule

// File: rtl/pred_cnt_sat_add.sv
module pred_cnt_sat_add #(
  parameter int CNT_W = 9
) (
  input  logic [63:0]      opnd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wide_i,
  output logic [63:0]      result_o
);
  import pred_cnt_pkg::*;

  sum_t op_ext, sum, limit;

  always_comb begin
    op_ext   = wide_i ? {1'b0, opnd_i} : SUM_W'(opnd_i[HALF_W-1:0]);
    limit    = wide_i ? {1'b0, {SCALAR_W{1'b1}}} : SUM_W'({HALF_W{1'b1}});
    sum      = op_ext + SUM_W'(cnt_i);
    result_o = (sum > limit) ? limit[SCALAR_W-1:0] : sum[SCALAR_W-1:0];
  end
endmodule

// File: rtl/pred_cnt_incr.sv
module pred_cnt_incr #(
  parameter int MAX_VL = 2048,
  localparam int PW    = MAX_VL / 8,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic [1:0]      esz_i,
  input  logic            wide_i,
  input  logic [PW-1:0]   pred_i,
  input  logic [63:0]     opnd_i,
  output logic            valid_o,
  output logic [63:0]     result_o
);
  localparam int CW = $clog2(PW + 1);

  logic [PW-1:0] mask;
  logic [CW-1:0] cnt;
  logic [63:0]   res_d;

  pred_cnt_lane_mask #(.PW(PW), .VL_W(VL_W)) i_mask (
    .vl_i   (vl_i),
    .esz_i  (esz_i),
    .pred_i (pred_i),
    .mask_o (mask)
  );

  pred_cnt_popcount #(.W(PW), .CHUNK(8)) i_pcnt (
    .bits_i  (mask),
    .count_o (cnt)
  );

  pred_cnt_sat_add #(.CNT_W(CW)) i_sat (
    .opnd_i   (opnd_i),
    .cnt_i    (cnt),
    .wide_i   (wide_i),
    .result_o (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end

  // input legality and count bound
  assert_vl_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ((vl_i % VL_W'(128)) == '0 && vl_i != '0 && 32'(vl_i) <= MAX_VL));
  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (32'(cnt) <= (32'(vl_i) >> (3 + 32'(esz_i)))));

  // output timing
  assert_valid_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  // value relations
  assert_narrow_upper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |=> (result_o[63:32] == 32'h0));
  assert_zero_pred_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i == '0) |=>
      (result_o == $past(wide_i ? opnd_i : {32'h0, opnd_i[31:0]})));
  assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (result_o >= $past(wide_i ? opnd_i : {32'h0, opnd_i[31:0]})));
  assert_sat_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wide_i && opnd_i == '1) |=> (result_o == '1));
endmodule

// File: tb/test_pred_cnt_incr.sv
`timescale 1ns/1ps
module test_pred_cnt_incr;
  localparam int MAX_VL = 256;
  localparam int PW     = MAX_VL / 8;
  localparam int VL_W   = $clog2(MAX_VL + 1);

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [VL_W-1:0] vl_i = '0;
  logic [1:0]      esz_i = '0;
  logic            wide_i = 1'b0;
  logic [PW-1:0]   pred_i = '0;
  logic [63:0]     opnd_i = '0;
  logic            valid_o;
  logic [63:0]     result_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pred_cnt_incr #(.MAX_VL(MAX_VL)) i_pred_cnt_incr (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .vl_i(vl_i), .esz_i(esz_i),
    .wide_i(wide_i), .pred_i(pred_i), .opnd_i(opnd_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [PW-1:0] pat(int p);
    case (p)
      0:  return '0;
      1:  return '1;
      2:  return 32'hAAAA_AAAA;
      3:  return 32'hFFFF_0000;
      4:  return 32'h0101_0101;
      5:  return 32'h1111_1111;
      6:  return 32'h5555_5555;
      7:  return 32'h0000_0001;
      8:  return 32'h8000_0000;
      9:  return 32'h0000_FFFF;
      default: return 32'h9E37_79B9 ^ (32'(p) * 32'h0100_0193);
    endcase
  endfunction

  function automatic logic [63:0] opv(int k);
    case (k)
      0: return 64'h0;
      1: return 64'h5;
      2: return 64'h0000_0000_FFFF_FFF0;
      3: return 64'h0000_0000_FFFF_FFFF;
      4: return 64'hDEAD_BEEF_0000_0003;
      5: return 64'hFFFF_FFFF_FFFF_FFF8;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  function automatic int count_active(int vl, int esz, logic [PW-1:0] p);
    int eb = 1 << esz;
    int ne = vl / (8 * eb);
    int c = 0;
    for (int e = 0; e < ne; e++) if (p[e*eb]) c++;
    return c;
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check64("R8 reset valid", 64'(valid_o), 64'h0);
    check64("R8 reset result", result_o, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int v = 1; v <= 2; v++) begin
      for (int s = 0; s < 4; s++) begin
        for (int w = 0; w < 2; w++) begin
          for (int p = 0; p < 12; p++) begin
            for (int k = 0; k < 7; k++) begin
              logic [63:0] op, mx, exp, held;
              logic [64:0] sum;
              int c;
              string tag;
              op  = opv(k);
              mx  = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
              c   = count_active(v * 128, s, pat(p));
              sum = {1'b0, (w ? op : {32'h0, op[31:0]})} + 65'(c);
              exp = (sum > {1'b0, mx}) ? mx : sum[63:0];
              case (p)
                0: tag = "R7";
                1: tag = "R1";
                2: tag = "R3";
                3: tag = "R2";
                default: tag = "R6";
              endcase
              if (sum > {1'b0, mx}) tag = "R5";
              else if (w == 0 && op[63:32] != 0) tag = "R4";
              else if (v == 2 && p == 8) tag = "R9";
              vl_i = VL_W'(v * 128); esz_i = 2'(s); wide_i = w[0];
              pred_i = pat(p); opnd_i = op; valid_i = 1'b1;
              @(negedge clk);
              check64({tag, " result"}, result_o, exp);
              check64("R8 valid due", 64'(valid_o), 64'h1);
              held = result_o;
              valid_i = 1'b0; opnd_i = ~op; pred_i = ~pat(p);
              @(negedge clk);
              check64("R8 idle valid", 64'(valid_o), 64'h0);
              check64("R8 hold result", result_o, held);
            end
          end
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule